// File: doc/BRIEF.md
# HyperBus Memory Controller Core

This core connects a simple streaming client to an external 8-bit double-data-rate pseudo-SRAM on a HyperBus-style bus. A client issues one command on a valid/ready channel. The command holds a direction bit, an address-space bit, a burst-type bit and a word address. The core then:

- drives the 48-bit command/address phase,
- waits out the initial access latency,
- streams 16-bit words until the client ends the burst.

Write words arrive on a write-data channel that has byte enables but no valid input, so the client must keep to fixed timing. Read words leave on a read-data channel that has no backpressure. The pin level is modelled as a single-clock view of the DDR bus. Each clock cycle carries two bytes. The byte for the rising edge is in bits 15:8 and the byte for the falling edge is in bits 7:0. The RWDS strobe is modelled the same way, as a 2-bit value per cycle, rising-edge bit first.

A write burst ends on the word flagged last. A read burst ends when the client raises `rdata_last` alongside a valid word. The device may already be returning the next word by then. The core drops that word and never presents it. After each burst, chip select returns high and stays high for a minimum idle time before a new command is taken.

Top module: `hbus_ctrl`

## Requirements
- R1: `cmd_ready` is high only in the idle state. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` falls in the next cycle. A `cmd_valid` pulse while `cmd_ready` is low has no effect.
- R2: In the three cycles after acceptance, `hb_cs_n` is low and `hb_dq_oe` is high. `hb_dq_o` carries the 48-bit command/address word 16 bits per cycle, most significant part first. The word layout is:
  - bit 47: 1 = write;
  - bit 46: 1 = register space;
  - bit 45: 1 = linear burst;
  - bits 44:16: address bits 31:3;
  - bits 15:3: zero;
  - bits 2:0: address bits 2:0.
- R3: Memory accesses and register reads wait LATENCY cycles after the command/address phase before the first data cycle. During that wait `wdata_ready` is low and `hb_cs_n` stays low.
- R4: If `hb_rwds_i[1]` is sampled high in any command/address cycle, the wait doubles to 2*LATENCY cycles.
- R5: A register write has no wait: the data phase begins right after the command/address phase. Byte enables are ignored and RWDS is not driven (`hb_rwds_oe` low), so the full word is written.
- R6: In every memory-write data cycle:
  - `wdata_ready` is high;
  - `hb_dq_o` equals `wdata_data`;
  - `hb_rwds_oe` is high;
  - `hb_rwds_o` is the inverted `wdata_be`, a 1 masking that byte.
- R7: A write burst of any length ends on the word with `wdata_last` high. In the next cycle `wdata_ready` is low and `hb_cs_n` is high.
- R8: During the read data phase, each cycle with `hb_rwds_i` = 2'b10 yields `rdata_valid` high for exactly one cycle in the following cycle. The word holds the rising-edge byte in bits 15:8 and the falling-edge byte in bits 7:0. Cycles without that strobe yield no valid word, and the core does not drive DQ.
- R9: When `rdata_last` is high together with `rdata_valid`, no further `rdata_valid` appears for that command. This holds even if the device strobes another word. `hb_cs_n` is high in the next cycle.
- R10: After a burst, `hb_cs_n` stays high and `cmd_ready` stays low for IDLE_CYC cycles. `cmd_ready` then rises.
- R11: During and right after reset, `hb_cs_n` is high and `hb_dq_oe`, `hb_rwds_oe`, `wdata_ready` and `rdata_valid` are low. `cmd_ready` is high once reset is released.
- R12: A register-space write always sends the linear-burst bit (bit 45) as 1, whatever `cmd_linear` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Core can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_regspace | input | 1 | 1 = register space, 0 = memory |
| cmd_linear | input | 1 | 1 = linear burst, 0 = wrapped/hybrid |
| cmd_addr | input | ADDR_W | Word address |
| wdata_data | input | 16 | Write word |
| wdata_be | input | 2 | Byte enables, bit 1 = upper byte |
| wdata_last | input | 1 | Final write word of the burst |
| wdata_ready | output | 1 | Write word consumed this cycle |
| rdata_data | output | 16 | Read word |
| rdata_valid | output | 1 | Read word present for this cycle only |
| rdata_last | input | 1 | Client ends the read burst at this word |
| hb_cs_n | output | 1 | Chip select, active low |
| hb_dq_o | output | 16 | DQ out, rising byte in 15:8 |
| hb_dq_oe | output | 1 | DQ output enable |
| hb_dq_i | input | 16 | DQ in, rising byte in 15:8 |
| hb_rwds_o | output | 2 | RWDS out, rising edge in bit 1 |
| hb_rwds_oe | output | 1 | RWDS output enable |
| hb_rwds_i | input | 2 | RWDS in, rising edge in bit 1 |

## Verification
The assertions rest on the following assumptions about the inputs:
- The client holds each write word stable until the cycle in which `wdata_ready` accepts it.
- The client raises `rdata_last` only in a cycle where `rdata_valid` is high.
- The device model strobes RWDS only while chip select is low.

The bench keeps to these assumptions. It presents each write word during the data cycle that consumes it. It raises `rdata_last` only when it has just seen a valid word. It drives RWDS low outside the command/address and read phases, except for the single extra strobe it injects after the last read word to provoke a suppressed read.

// File: rtl/hbus_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the HyperBus controller core.
// Assumes a 16-bit word and a 48-bit command/address word.
package hbus_pkg;
    localparam int unsigned HB_WORD_W   = 16;
    localparam int unsigned HB_CA_W     = 48;
    localparam int unsigned HB_CA_BEATS = HB_CA_W / HB_WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA,
        ST_LAT,
        ST_WR,
        ST_RD,
        ST_GAP
    } hb_state_e;

    // Pack the command/address word; register writes force linear burst.
    function automatic logic [HB_CA_W-1:0] hb_build_ca(
        input logic        wr,
        input logic        regsp,
        input logic        linear,
        input logic [31:0] addr
    );
        logic [HB_CA_W-1:0] ca;
        ca        = '0;
        ca[47]    = wr;
        ca[46]    = regsp;
        ca[45]    = linear | (wr & regsp);
        ca[44:16] = addr[31:3];
        ca[2:0]   = addr[2:0];
        return ca;
    endfunction
endpackage

// File: rtl/hbus_ca_pack.sv
`timescale 1ns/1ps
// Command/address serialiser. Builds the 48-bit word when a command is
// taken and presents it 16 bits per cycle, most significant part first.
// Assumes ADDR_W <= 32 and that step is high only during the CA phase.
module hbus_ca_pack
    import hbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic                 wr,
    input  logic                 regsp,
    input  logic                 linear,
    input  logic [ADDR_W-1:0]    addr,
    output logic [HB_WORD_W-1:0] beat_o,
    output logic                 last_beat_o
);
    localparam int unsigned BW = $clog2(HB_CA_BEATS);

    logic [HB_CA_W-1:0] sr_q;
    logic [BW-1:0]      beat_q;
    logic [31:0]        addr32;

    assign addr32 = 32'(addr);

    // Load the word on acceptance, shift one beat per CA cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            beat_q <= '0;
        end else if (load) begin
            sr_q   <= hb_build_ca(wr, regsp, linear, addr32);
            beat_q <= '0;
        end else if (step) begin
            sr_q   <= {sr_q[HB_CA_W-HB_WORD_W-1:0], {HB_WORD_W{1'b0}}};
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat_o      = sr_q[HB_CA_W-1 -: HB_WORD_W];
    assign last_beat_o = (beat_q == BW'(HB_CA_BEATS - 1));
endmodule

// File: rtl/hbus_down_cnt.sv
`timescale 1ns/1ps
// Loadable down-counter used for the access latency and the idle gap.
// done_o is high while the count is zero. Assumes load_val <= MAXV.
module hbus_down_cnt #(
    parameter int unsigned MAXV = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [$clog2(MAXV+1)-1:0]       load_val,
    output logic                            done_o
);
    localparam int unsigned CW = $clog2(MAXV + 1);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);

    // R3
    cnt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/hbus_rd_capture.sv
`timescale 1ns/1ps
// Read-word capture. A full RWDS strobe (high on the rising edge, low on
// the falling edge) marks one word: rising byte high, falling byte low.
// The word is offered for one cycle; kill drops words after the last one.
module hbus_rd_capture
    import hbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 kill,
    input  logic [1:0]           rwds_i,
    input  logic [HB_WORD_W-1:0] dq_i,
    output logic                 valid_o,
    output logic [HB_WORD_W-1:0] data_o
);
    localparam int unsigned BYTE_W = HB_WORD_W / 2;

    logic strobe;

    assign strobe = (rwds_i == 2'b10);

    // Register the assembled word and its one-cycle valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= en && strobe && !kill;
            if (strobe)
                data_o <= {dq_i[HB_WORD_W-1 -: BYTE_W], dq_i[BYTE_W-1:0]};
        end
    end

    // R8
    cap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(rwds_i) == 2'b10));
endmodule

// File: rtl/hbus_ctrl.sv
`timescale 1ns/1ps
// HyperBus controller core. Takes one command at a time, drives the
// command/address phase, waits the access latency (doubled when the
// device flags it on RWDS during CA), then streams write or read words
// until the client ends the burst. Chip select then idles high for
// IDLE_CYC cycles. Assumes LATENCY >= 1, IDLE_CYC >= 1, ADDR_W <= 32,
// write words held stable until consumed, and rdata_last only with valid.
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LATENCY  = 6,
    parameter int unsigned IDLE_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic                 cmd_write,
    input  logic                 cmd_regspace,
    input  logic                 cmd_linear,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [HB_WORD_W-1:0] wdata_data,
    input  logic [1:0]           wdata_be,
    input  logic                 wdata_last,
    output logic                 wdata_ready,
    output logic [HB_WORD_W-1:0] rdata_data,
    output logic                 rdata_valid,
    input  logic                 rdata_last,
    output logic                 hb_cs_n,
    output logic [HB_WORD_W-1:0] hb_dq_o,
    output logic                 hb_dq_oe,
    input  logic [HB_WORD_W-1:0] hb_dq_i,
    output logic [1:0]           hb_rwds_o,
    output logic                 hb_rwds_oe,
    input  logic [1:0]           hb_rwds_i
);
    localparam int unsigned LAT_MAX = 2 * LATENCY;
    localparam int unsigned LAT_CW  = $clog2(LAT_MAX + 1);
    localparam int unsigned GAP_CW  = $clog2(IDLE_CYC + 1);
    localparam logic [LAT_CW-1:0] LAT_SHORT = LAT_CW'(LATENCY - 1);
    localparam logic [LAT_CW-1:0] LAT_LONG  = LAT_CW'(LAT_MAX - 1);
    localparam logic [GAP_CW-1:0] GAP_VAL   = GAP_CW'(IDLE_CYC - 1);

    hb_state_e             state_q, state_d;
    logic                  wr_q, reg_q, dbl_q;
    logic                  accept, ca_last, lat_done, gap_done;
    logic                  lat_load, gap_load, wr_end, rd_end;
    logic                  reg_write;
    logic [HB_WORD_W-1:0]  ca_beat;
    logic [LAT_CW-1:0]     lat_val;

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign reg_write = wr_q && reg_q;
    assign wr_end    = (state_q == ST_WR) && wdata_last;
    assign rd_end    = (state_q == ST_RD) && rdata_valid && rdata_last;
    assign lat_val   = (dbl_q || hb_rwds_i[1]) ? LAT_LONG : LAT_SHORT;
    assign lat_load  = (state_q == ST_CA) && ca_last && !reg_write;
    assign gap_load  = wr_end || rd_end;

    // Keep the accepted direction/space and the doubled-latency flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            reg_q <= 1'b0;
            dbl_q <= 1'b0;
        end else if (accept) begin
            wr_q  <= cmd_write;
            reg_q <= cmd_regspace;
            dbl_q <= 1'b0;
        end else if ((state_q == ST_CA) && hb_rwds_i[1]) begin
            dbl_q <= 1'b1;
        end
    end

    // Choose the next phase of the transfer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept)   state_d = ST_CA;
            ST_CA:   if (ca_last)  state_d = reg_write ? ST_WR : ST_LAT;
            ST_LAT:  if (lat_done) state_d = wr_q ? ST_WR : ST_RD;
            ST_WR:   if (wr_end)   state_d = ST_GAP;
            ST_RD:   if (rd_end)   state_d = ST_GAP;
            ST_GAP:  if (gap_done) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    hbus_ca_pack #(.ADDR_W(ADDR_W)) ca_pack_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .step        (state_q == ST_CA),
        .wr          (cmd_write),
        .regsp       (cmd_regspace),
        .linear      (cmd_linear),
        .addr        (cmd_addr),
        .beat_o      (ca_beat),
        .last_beat_o (ca_last)
    );

    hbus_down_cnt #(.MAXV(LAT_MAX)) lat_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (lat_val),
        .done_o   (lat_done)
    );

    hbus_down_cnt #(.MAXV(IDLE_CYC)) gap_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (GAP_VAL),
        .done_o   (gap_done)
    );

    hbus_rd_capture rd_cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state_q == ST_RD),
        .kill    (rdata_valid && rdata_last),
        .rwds_i  (hb_rwds_i),
        .dq_i    (hb_dq_i),
        .valid_o (rdata_valid),
        .data_o  (rdata_data)
    );

    // Drive the bus pins from the current phase.
    always_comb begin
        hb_cs_n     = !((state_q == ST_CA) || (state_q == ST_LAT) ||
                        (state_q == ST_WR) || (state_q == ST_RD));
        hb_dq_oe    = (state_q == ST_CA) || (state_q == ST_WR);
        wdata_ready = (state_q == ST_WR);
        hb_rwds_oe  = (state_q == ST_WR) && !reg_q;
        hb_dq_o     = '0;
        if (state_q == ST_CA)      hb_dq_o = ca_beat;
        else if (state_q == ST_WR) hb_dq_o = wdata_data;
        hb_rwds_o   = hb_rwds_oe ? ~wdata_be : 2'b00;
    end

    // R1
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R2
    dq_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hb_dq_oe |-> !hb_cs_n);

    // R7
    wr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata_ready && wdata_last) |=> (!wdata_ready && hb_cs_n));

    // R9
    rd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_valid && rdata_last) |=> !rdata_valid);

    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hb_cs_n) |=> (hb_cs_n && !cmd_ready));
endmodule

// File: tb/hbus_ctrl_tb.sv
`timescale 1ns/1ps
module hbus_ctrl_tb_top;
    localparam int LAT  = 3;
    localparam int IDLE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_regspace = 1'b0, cmd_linear = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [15:0] wdata_data = '0;
    logic [1:0]  wdata_be = '0;
    logic        wdata_last = 1'b0, wdata_ready;
    logic [15:0] rdata_data;
    logic        rdata_valid, rdata_last = 1'b0;
    logic        hb_cs_n, hb_dq_oe, hb_rwds_oe;
    logic [15:0] hb_dq_o, hb_dq_i = '0;
    logic [1:0]  hb_rwds_o, hb_rwds_i = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hbus_ctrl #(.ADDR_W(32), .LATENCY(LAT), .IDLE_CYC(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_regspace(cmd_regspace), .cmd_linear(cmd_linear), .cmd_addr(cmd_addr),
        .wdata_data(wdata_data), .wdata_be(wdata_be), .wdata_last(wdata_last),
        .wdata_ready(wdata_ready), .rdata_data(rdata_data), .rdata_valid(rdata_valid),
        .rdata_last(rdata_last), .hb_cs_n(hb_cs_n), .hb_dq_o(hb_dq_o),
        .hb_dq_oe(hb_dq_oe), .hb_dq_i(hb_dq_i), .hb_rwds_o(hb_rwds_o),
        .hb_rwds_oe(hb_rwds_oe), .hb_rwds_i(hb_rwds_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_txn(input bit we, input bit rg, input bit ln, input logic [31:0] ad,
                           input int len, input bit dbl, input bit gap);
        logic [47:0] ca;
        logic [15:0] w;
        logic [1:0]  be;
        int          wait_n;
        ca = {we, rg, ln | (we & rg), ad[31:3], 13'd0, ad[2:0]};
        cmd_valid = 1'b1; cmd_write = we; cmd_regspace = rg; cmd_linear = ln; cmd_addr = ad;
        #1;
        chk(cmd_ready == 1'b1, "R1 ready before accept", 48'(cmd_ready), 48'd1);
        tick();
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R1 ready low after accept", 48'(cmd_ready), 48'd0);
        for (int b = 0; b < 3; b++) begin
            chk(!hb_cs_n && hb_dq_oe, "R2 CA bus driven", {46'd0, hb_cs_n, hb_dq_oe}, 48'd1);
            chk(hb_dq_o == ca[47-16*b -: 16], (rg && we) ? "R12 CA beat reg write" : "R2 CA beat",
                48'(hb_dq_o), 48'(ca[47-16*b -: 16]));
            hb_rwds_i = (b == 0 && dbl) ? 2'b10 : 2'b00;
            tick();
        end
        hb_rwds_i = 2'b00;
        wait_n = (we && rg) ? 0 : LAT * (dbl ? 2 : 1);
        for (int k = 0; k < wait_n; k++) begin
            chk(!wdata_ready && !hb_cs_n && !rdata_valid, dbl ? "R4 doubled wait" : "R3 wait",
                {45'd0, wdata_ready, hb_cs_n, rdata_valid}, 48'd0);
            tick();
        end
        if (we) begin
            chk(wdata_ready == 1'b1, (wait_n == 0) ? "R5 zero latency start" : (dbl ? "R4 data start" : "R3 data start"),
                48'(wdata_ready), 48'd1);
            for (int i = 0; i < len; i++) begin
                w = 16'hA55A ^ 16'(ad[15:0] + 16'(i * 4099));
                be = 2'(i + 1);
                wdata_data = w; wdata_be = be; wdata_last = (i == len - 1);
                #1;
                chk(wdata_ready && hb_dq_oe && hb_dq_o == w, "R6 write word on bus", 48'(hb_dq_o), 48'(w));
                if (rg)
                    chk(!hb_rwds_oe, "R5 mask not driven", 48'(hb_rwds_oe), 48'd0);
                else
                    chk(hb_rwds_oe && hb_rwds_o == ~be, "R6 write mask", {45'd0, hb_rwds_oe, hb_rwds_o},
                        {45'd0, 1'b1, ~be});
                tick();
            end
            wdata_last = 1'b0;
            chk(hb_cs_n && !wdata_ready, "R7 write end", {46'd0, hb_cs_n, wdata_ready}, 48'd2);
        end else begin
            for (int i = 0; i < len; i++) begin
                w = 16'(ad[15:0] * 3 + 16'(i * 257)) ^ 16'h3C0F;
                hb_rwds_i = 2'b10; hb_dq_i = w;
                chk(!hb_dq_oe, "R8 DQ released in read", 48'(hb_dq_oe), 48'd0);
                tick();
                chk(rdata_valid && rdata_data == w, "R8 read word", {31'd0, rdata_valid, rdata_data},
                    {31'd0, 1'b1, w});
                if (i == len - 1) begin
                    rdata_last = 1'b1;
                    hb_rwds_i = 2'b10; hb_dq_i = ~w;
                    tick();
                    chk(!rdata_valid && hb_cs_n, "R9 no valid after last", {46'd0, rdata_valid, hb_cs_n}, 48'd1);
                    rdata_last = 1'b0; hb_rwds_i = 2'b00;
                end else if (gap) begin
                    hb_rwds_i = 2'b00;
                    tick();
                    chk(!rdata_valid, "R8 no strobe no word", 48'(rdata_valid), 48'd0);
                end
            end
        end
        for (int k = 0; k < IDLE; k++) begin
            chk(hb_cs_n && !cmd_ready, "R10 idle gap", {46'd0, hb_cs_n, cmd_ready}, 48'd2);
            cmd_valid = (k == 0);
            cmd_write = ~we;
            tick();
        end
        cmd_valid = 1'b0;
        chk(hb_cs_n, "R1 command ignored while not ready", 48'(hb_cs_n), 48'd1);
        chk(cmd_ready, "R10 ready after gap", 48'(cmd_ready), 48'd1);
    endtask

    initial begin
        int lens[4] = '{1, 2, 3, 5};
        int n = 0;
        repeat (3) tick();
        chk(hb_cs_n && !hb_dq_oe && !hb_rwds_oe && !wdata_ready && !rdata_valid, "R11 outputs in reset",
            {43'd0, hb_cs_n, hb_dq_oe, hb_rwds_oe, wdata_ready, rdata_valid}, 48'h10);
        rst_n = 1'b1;
        tick();
        chk(cmd_ready && hb_cs_n, "R11 ready after reset", {46'd0, cmd_ready, hb_cs_n}, 48'd3);
        for (int we = 0; we < 2; we++)
            for (int rg = 0; rg < 2; rg++)
                for (int ln = 0; ln < 2; ln++)
                    for (int dbl = 0; dbl < 2; dbl++)
                        for (int li = 0; li < 4; li++) begin
                            n++;
                            run_txn(we[0], rg[0], ln[0], 32'h0123_4567 ^ (32'(n) * 32'h0101_0F1B),
                                    lens[li], dbl[0], li[0]);
                        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule